// File: doc/BRIEF.md
# Cache-aware DRAM read sequencer

This block decides when a local DRAM cycle may begin on a CPU bus shared with an external cache controller. A cycle request arrives as a one-cycle start pulse, together with a write flag and a claim flag from any external controller. Two mode enables switch cache cooperation on: a local-bus-access mode and an early-ready mode. When either mode is on, every unclaimed read first spends one decision cycle. During that cycle the cache controller may report a hit. A hit cancels the DRAM access and a miss lets it go ahead.

The block issues a one-cycle DRAM start pulse. After a fixed access length it raises ready. Parity checking of returned read data is enabled only for reads that were actually served from DRAM, so cache hits need no parity storage in the cache. A parity error is reported only while the check is enabled. Writes never pay for the decision cycle, so the extra latency costs time only on read misses.

Top module: `cache_dram_seq`

## Requirements
- R1: After reset is released and before any start, `dram_go_o`, `rdy_o`, `par_chk_o` and `par_err_o` are all 0.
- R2: With both mode enables at 0, an unclaimed read started at clock edge k gives `dram_go_o`=1 for exactly the cycle after edge k. It gives `rdy_o`=1 for exactly one cycle, ACC_CYC+1 cycles after edge k, with `par_chk_o`=1 in that cycle.
- R3: With either mode enable at 1, an unclaimed read gets one decision cycle first, so no DRAM start occurs in the cycle after edge k.
- R4: A write (`cyc_write_i`=1) never gets a decision cycle, whatever the modes. It starts DRAM in the cycle after edge k and completes ACC_CYC+1 cycles after edge k with `par_chk_o`=0.
- R5: `hit_i`=1 during the decision cycle cancels the DRAM access: `dram_go_o` stays 0 for that request.
- R6: On a hit with early-ready mode on, the block gives no `rdy_o`, because the cache supplies ready with zero wait states. On a hit with only local-bus-access mode on, `rdy_o`=1 in the cycle after the decision cycle, with `par_chk_o`=0.
- R7: On a miss, `dram_go_o`=1 in the cycle after the decision cycle and `rdy_o`=1 ACC_CYC+2 cycles after edge k, with `par_chk_o`=1.
- R8: `hit_i` outside the decision cycle has no effect on any output.
- R9: A start with `claim_i`=1 produces no `dram_go_o`, no `rdy_o`, no `par_chk_o` and no `par_err_o`.
- R10: `par_err_o` equals `par_bad_i` while `par_chk_o`=1 and is 0 otherwise.
- R11: A start pulse that arrives while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | One-cycle start of a local memory cycle |
| cyc_write_i | input | 1 | 1 = write cycle, 0 = read cycle, valid with start |
| claim_i | input | 1 | External controller claims the cycle, valid with start |
| hit_i | input | 1 | Cache hit report, used only in the decision cycle |
| lba_mode_i | input | 1 | Local-bus-access cache mode enable |
| erdy_mode_i | input | 1 | Early-ready cache mode enable |
| par_bad_i | input | 1 | Raw parity mismatch of the read data |
| dram_go_o | output | 1 | One-cycle DRAM cycle start |
| rdy_o | output | 1 | Cycle completion from this block |
| par_chk_o | output | 1 | Parity check enabled for the completing read |
| par_err_o | output | 1 | Qualified parity error |

## Verification
A state machine stuck in, or skipping, the decision state shows up at the ports within two cycles of a read start. In that case `dram_go_o` comes one cycle early or late, or it appears after a hit. A wrong access counter shifts `rdy_o` away from ACC_CYC+1 or ACC_CYC+2 cycles after the start. A wrong latched read flag or hit flag shows in the same ready cycle as a wrong `par_chk_o`, and hence a wrong `par_err_o` under random parity noise. Claimed cycles and hits outside the slot are checked by watching all four outputs for the whole response window.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_ACCESS,
    ST_FINISH,
    ST_HITFIN
  } seq_st_e;
endpackage

// File: rtl/cds_path_sel.sv
module cds_path_sel (
  input  logic idle_i,
  input  logic start_i,
  input  logic write_i,
  input  logic claim_i,
  input  logic lba_i,
  input  logic erdy_i,
  output logic take_o,
  output logic slot_o
);
  // claimed cycles belong to the other controller
  assign take_o = idle_i & start_i & ~claim_i;
  // reads only get the decision slot, and only with a cache mode on
  assign slot_o = take_o & ~write_i & (lba_i | erdy_i);
endmodule

// File: rtl/cds_wait_ctr.sv
module cds_wait_ctr #(
  parameter int unsigned ACC_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic first_o,
  output logic last_o
);
  localparam int unsigned CNT_W = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || last_o)       cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = run_i & (cnt_q == '0);
  assign last_o  = run_i & (cnt_q == CNT_LAST);
endmodule

// File: rtl/cds_out_gen.sv
module cds_out_gen
  import cds_pkg::*;
(
  input  seq_st_e st_i,
  input  logic    first_i,
  input  logic    rd_i,
  input  logic    par_bad_i,
  output logic    dram_go_o,
  output logic    rdy_o,
  output logic    par_chk_o,
  output logic    par_err_o
);
  assign dram_go_o = (st_i == ST_ACCESS) & first_i;
  assign rdy_o     = (st_i == ST_FINISH) | (st_i == ST_HITFIN);
  // only DRAM-served reads are checked
  assign par_chk_o = (st_i == ST_FINISH) & rd_i;
  assign par_err_o = par_chk_o & par_bad_i;
endmodule

// File: rtl/cache_dram_seq.sv
module cache_dram_seq
  import cds_pkg::*;
#(
  parameter int unsigned ACC_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_start_i,
  input  logic cyc_write_i,
  input  logic claim_i,
  input  logic hit_i,
  input  logic lba_mode_i,
  input  logic erdy_mode_i,
  input  logic par_bad_i,
  output logic dram_go_o,
  output logic rdy_o,
  output logic par_chk_o,
  output logic par_err_o
);
  seq_st_e state_q, state_d;
  logic    rd_q, erdy_q;
  logic    take, slot, cnt_first, cnt_last, idle;

  assign idle = (state_q == ST_IDLE);

  cds_path_sel i_path (
    .idle_i  (idle),
    .start_i (cyc_start_i),
    .write_i (cyc_write_i),
    .claim_i (claim_i),
    .lba_i   (lba_mode_i),
    .erdy_i  (erdy_mode_i),
    .take_o  (take),
    .slot_o  (slot)
  );

  cds_wait_ctr #(.ACC_CYC(ACC_CYC)) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_ACCESS),
    .first_o (cnt_first),
    .last_o  (cnt_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (slot) state_d = ST_DECIDE;
                 else if (take) state_d = ST_ACCESS;
      ST_DECIDE: if (!hit_i) state_d = ST_ACCESS;
                 else if (erdy_q) state_d = ST_IDLE; // cache drives ready
                 else state_d = ST_HITFIN;
      ST_ACCESS: if (cnt_last) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      ST_HITFIN: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      erdy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        rd_q   <= ~cyc_write_i;
        erdy_q <= erdy_mode_i;
      end
    end
  end

  cds_out_gen i_out (
    .st_i      (state_q),
    .first_i   (cnt_first),
    .rd_i      (rd_q),
    .par_bad_i (par_bad_i),
    .dram_go_o (dram_go_o),
    .rdy_o     (rdy_o),
    .par_chk_o (par_chk_o),
    .par_err_o (par_err_o)
  );
endmodule

// File: rtl/cache_dram_seq_chk.sv
module cache_dram_seq_chk
  import cds_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    cyc_start_i,
  input logic    cyc_write_i,
  input logic    claim_i,
  input logic    hit_i,
  input logic    lba_mode_i,
  input logic    erdy_mode_i,
  input logic    dram_go_o,
  input logic    rdy_o,
  input logic    par_chk_o,
  input logic    par_err_o,
  input seq_st_e state_q
);
  logic idle;
  assign idle = (state_q == ST_IDLE);

  // R2
  direct_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cyc_start_i && !claim_i && !lba_mode_i && !erdy_mode_i) |=> dram_go_o);
  // R4
  write_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cyc_start_i && !claim_i && cyc_write_i) |=> dram_go_o);
  // R3
  slot_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cyc_start_i && !claim_i && !cyc_write_i && (lba_mode_i || erdy_mode_i))
      |=> (!dram_go_o && state_q == ST_DECIDE));
  // R5
  hit_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE && hit_i) |=> !dram_go_o);
  // R7
  miss_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE && !hit_i) |=> dram_go_o);
  // R9
  claim_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cyc_start_i && claim_i) |=> (!dram_go_o && !rdy_o && idle));
  // R10
  par_err_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> par_chk_o);
  // R6
  par_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_chk_o |-> rdy_o);
  // R2
  go_rdy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dram_go_o, rdy_o}));
endmodule

bind cache_dram_seq cache_dram_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_start_i (cyc_start_i),
  .cyc_write_i (cyc_write_i),
  .claim_i     (claim_i),
  .hit_i       (hit_i),
  .lba_mode_i  (lba_mode_i),
  .erdy_mode_i (erdy_mode_i),
  .dram_go_o   (dram_go_o),
  .rdy_o       (rdy_o),
  .par_chk_o   (par_chk_o),
  .par_err_o   (par_err_o),
  .state_q     (state_q)
);

// File: tb/test_cache_dram_seq.sv
module test_cache_dram_seq;
  localparam int ACC = 3;
  localparam int WIN = ACC + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0, claim = 1'b0, hit = 1'b0;
  logic lba = 1'b0, erdy = 1'b0, pbad = 1'b0;
  logic go, rdy, pchk, perr;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  cache_dram_seq #(.ACC_CYC(ACC)) i_cache_dram_seq (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(start), .cyc_write_i(wr),
    .claim_i(claim), .hit_i(hit), .lba_mode_i(lba), .erdy_mode_i(erdy),
    .par_bad_i(pbad), .dram_go_o(go), .rdy_o(rdy), .par_chk_o(pchk),
    .par_err_o(perr)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // expected window index of dram start (0 = none)
  function automatic int exp_go(bit w, bit c, bit l, bit e, bit h);
    if (c) return 0;
    if (w || !(l || e)) return 1;
    return h ? 0 : 2;
  endfunction

  function automatic int exp_rdy(bit w, bit c, bit l, bit e, bit h);
    if (c) return 0;
    if (w || !(l || e)) return 1 + ACC;
    if (h) return e ? 0 : 2;
    return 2 + ACC;
  endfunction

  function automatic int exp_par(bit w, bit c, bit l, bit e, bit h);
    if (c || w) return 0;
    if ((l || e) && h) return 0;
    return 1;
  endfunction

  task automatic run_req(bit w, bit c, bit l, bit e, bit h, bit noise, bit busy_start);
    int go_at = 0, go_n = 0, rdy_at = 0, rdy_n = 0, par_at_rdy = 0, perr_bad = 0;
    string tag;
    tag = c ? "R9" : (w ? "R4" : (!(l || e) ? "R2" : (h ? (e ? "R5/R6" : "R6") : "R7")));
    @(negedge clk);
    start = 1'b1; wr = w; claim = c; lba = l; erdy = e;
    hit = noise; // R8: hit alongside the start is outside the slot
    pbad = 1'($urandom);
    for (int j = 1; j <= WIN; j++) begin
      @(negedge clk);
      start = (j == 1) && busy_start && !c; // R11
      wr = 1'($urandom); claim = 1'b0;
      if (go)  begin go_n++;  if (go_at == 0) go_at = j; end
      if (rdy) begin rdy_n++; if (rdy_at == 0) begin rdy_at = j; par_at_rdy = pchk; end end
      if (perr != (pbad & pchk)) perr_bad++;
      if (!rdy && pchk) perr_bad++;
      hit = (j == 1) ? h : noise;
      pbad = 1'($urandom);
    end
    hit = 1'b0; start = 1'b0;
    chk({tag, " go index"}, go_at, exp_go(w, c, l, e, h));
    chk({tag, " go count"}, go_n, exp_go(w, c, l, e, h) != 0 ? 1 : 0);
    chk({tag, " rdy index"}, rdy_at, exp_rdy(w, c, l, e, h));
    chk({tag, " rdy count"}, rdy_n, exp_rdy(w, c, l, e, h) != 0 ? 1 : 0);
    chk({tag, " parity enable"}, par_at_rdy, exp_rdy(w, c, l, e, h) != 0 ? exp_par(w, c, l, e, h) : 0);
    chk("R10 parity error gating", perr_bad, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {go, rdy, pchk, perr}, 0);
    // directed corners
    run_req(0, 0, 0, 0, 0, 0, 0); // R2 plain read
    run_req(0, 0, 0, 0, 1, 1, 0); // R2/R8 hit with modes off ignored
    run_req(0, 0, 1, 0, 0, 0, 0); // R3 R7 miss
    run_req(0, 0, 0, 1, 1, 0, 0); // R5 R6 early-ready hit
    run_req(0, 0, 1, 0, 1, 0, 0); // R6 local-bus hit
    run_req(1, 0, 1, 1, 1, 1, 0); // R4 write ignores modes
    run_req(0, 1, 1, 1, 0, 1, 0); // R9 claimed
    run_req(0, 0, 1, 1, 0, 1, 1); // R8 R11 noise on miss
    // random mix
    for (int n = 0; n < 300; n++)
      run_req(1'($urandom), (($urandom % 5) == 0), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule